// File: doc/BRIEF.md
# System-Management Mode State Save/Restore Sequencer

This block lets a 32-bit core enter and leave a system-management mode. When a management interrupt is accepted, the block latches a snapshot of the architectural registers in parallel. It then writes a fixed 128-word image into memory just below the top of a 64 KiB window that starts at a programmable save base. After the last write it presents the mode-entry register values on its load outputs for one cycle.

A resume request made inside the mode reads the same 128 words back in the same order. It then presents the restored register values with a load strobe, and the mode and NMI-blocked flags clear. A resume request made outside the mode starts no memory traffic and raises a one-cycle undefined-opcode fault. Memory is reached through a word-wide request/acknowledge port. The core's register file applies the load outputs when the strobe is high. For an entry load it takes the entry set; for a resume load it takes the restored set.

Top module: `sysmgmt_seq`

## Requirements
- R1: While reset is asserted, busy, in_mgmt, nmi_blk, mem_req, ld_stb and ud_fault are all 0.
- R2: An accepted management interrupt performs exactly 128 write transactions (mem_we=1). The first is at save_base+0xFFFC, and each later one is 4 bytes lower.
- R3: A field at offset X is written at address save_base+0x8000+X. The offsets are: ctl0 0x7FFC, ctl3 0x7FF8, flags 0x7FF4, ip 0x7FF0, dbg6 0x7FCC, dbg7 0x7FC8, task selector 0x7FC4 (zero-extended), save base 0x7EF8. General register g (32-bit slice g of snap_gpr, g=0..7) goes at 0x7FD0+4g. Segment selector s (16-bit slice s of snap_seg_sel, s=0..5) goes at 0x7FA8+4s, zero-extended. All values are the ones present in the cycle the request is accepted.
- R4: Every other word of the image is written as zero.
- R5: After the last save write, ld_stb and ld_entry are 1 for one cycle. In that cycle: ld_ctl0 = snapshot ctl0 with bits 31, 3, 2 and 0 cleared; ld_ctl4 = 0; ld_dbg7 = 0x400; ld_flags = 0x2; ld_ip = 0x8000; ld_cs_sel = save_base[19:4]; ld_cs_base = save_base; ld_data_base = 0; ld_seg_limit = 0xFFFF. In the next cycle in_mgmt and nmi_blk are 1.
- R6: mgmt_irq is ignored while busy or in_mgmt: it starts no transactions and changes no flag.
- R7: resume_req while idle and outside the mode makes ud_fault 1 for exactly the following cycle, with no memory transaction.
- R8: An accepted resume performs exactly 128 read transactions (mem_we=0) at the same addresses and in the same order as R2. The addresses use the snap_save_base value present when the resume is accepted.
- R9: After the last read, ld_stb is 1 with ld_entry 0. ld_ctl0, ld_ctl3, ld_flags, ld_ip, ld_gpr, ld_dbg6, ld_dbg7 and ld_save_base equal the words read at the R3 offsets. In the next cycle in_mgmt and nmi_blk are 0.
- R10: While mem_req is high and not acknowledged, mem_addr, mem_we and mem_wdata hold their values.
- R11: busy rises in the cycle after a request is accepted, stays high through the ld_stb cycle, and falls right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_irq | input | 1 | Management interrupt request |
| resume_req | input | 1 | Resume-from-mode request |
| snap_ctl0 | input | 32 | Control register 0 snapshot |
| snap_ctl3 | input | 32 | Control register 3 snapshot |
| snap_flags | input | 32 | Flags snapshot |
| snap_ip | input | 32 | Instruction pointer snapshot |
| snap_gpr | input | 256 | Eight general registers, slice g = register g |
| snap_dbg6 | input | 32 | Debug status snapshot |
| snap_dbg7 | input | 32 | Debug control snapshot |
| snap_tr_sel | input | 16 | Task register selector |
| snap_seg_sel | input | 96 | Six segment selectors, slice s = selector s |
| snap_save_base | input | 32 | Current save base |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| ld_stb | output | 1 | Register load strobe |
| ld_entry | output | 1 | 1 = entry values, 0 = restored values |
| ld_ctl0 | output | 32 | Control register 0 value |
| ld_ctl3 | output | 32 | Control register 3 value |
| ld_ctl4 | output | 32 | Control register 4 value |
| ld_flags | output | 32 | Flags value |
| ld_ip | output | 32 | Instruction pointer value |
| ld_gpr | output | 256 | General register values |
| ld_dbg6 | output | 32 | Debug status value |
| ld_dbg7 | output | 32 | Debug control value |
| ld_save_base | output | 32 | Save base value |
| ld_cs_sel | output | 16 | Code segment selector |
| ld_cs_base | output | 32 | Code segment base |
| ld_data_base | output | 32 | Base for the five data segments |
| ld_seg_limit | output | 16 | Segment limit |
| busy | output | 1 | Sequence in progress |
| in_mgmt | output | 1 | Inside the management mode |
| nmi_blk | output | 1 | NMI blocked |
| ud_fault | output | 1 | Undefined-opcode fault pulse |

## Verification
The hardest case to reach is a resume that restores values different from the ones saved. That only happens if the image is changed in memory while the block is in the mode. The bench's memory model rewrites every restorable slot with fresh random words between entry and resume, and it moves snap_save_base right after each request is accepted. Acknowledge latency is random, and extra management interrupts are fired in the middle of a save, so the hold and ignore rules are exercised while transactions are still pending.

// File: rtl/sysmgmt_pkg.sv
`timescale 1ns/1ps
package sysmgmt_pkg;
  localparam int WORD_W    = 32;
  localparam int SEL_W     = 16;
  localparam int IMG_WORDS = 128;
  localparam int SLOT_W    = $clog2(IMG_WORDS);
  localparam int NUM_GPR   = 8;
  localparam int NUM_SEG   = 6;
  localparam logic [WORD_W-1:0] WINDOW_TOP = 32'h0001_0000;

  // save-area offset -> word slot (slot 0 is written first)
  function automatic int slot_of(int offset);
    return ((32'h8000 - offset) >> 2) - 1;
  endfunction

  localparam int SLOT_CTL0  = slot_of(32'h7FFC);
  localparam int SLOT_CTL3  = slot_of(32'h7FF8);
  localparam int SLOT_FLAGS = slot_of(32'h7FF4);
  localparam int SLOT_IP    = slot_of(32'h7FF0);
  localparam int SLOT_GPR0  = slot_of(32'h7FD0);
  localparam int SLOT_DBG6  = slot_of(32'h7FCC);
  localparam int SLOT_DBG7  = slot_of(32'h7FC8);
  localparam int SLOT_TR    = slot_of(32'h7FC4);
  localparam int SLOT_SEG0  = slot_of(32'h7FA8);
  localparam int SLOT_BASE  = slot_of(32'h7EF8);

  typedef struct packed {
    logic [WORD_W-1:0]                 ctl0, ctl3, flags, ip;
    logic [NUM_GPR-1:0][WORD_W-1:0]    gpr;
    logic [WORD_W-1:0]                 dbg6, dbg7;
    logic [SEL_W-1:0]                  tr_sel;
    logic [NUM_SEG-1:0][SEL_W-1:0]     seg_sel;
    logic [WORD_W-1:0]                 base;
  } snap_t;

  typedef struct packed {
    logic [WORD_W-1:0]                 ctl0, ctl3, flags, ip;
    logic [NUM_GPR-1:0][WORD_W-1:0]    gpr;
    logic [WORD_W-1:0]                 dbg6, dbg7;
    logic [WORD_W-1:0]                 base;
  } restore_t;

  typedef enum logic [2:0] {PH_IDLE, PH_SAVE, PH_ENTER, PH_LOAD, PH_EXIT} phase_t;

  function automatic logic [WORD_W-1:0] word_addr(logic [WORD_W-1:0] base,
                                                  logic [SLOT_W-1:0] slot);
    return base + WINDOW_TOP - ((32'(slot) + 32'd1) << 2);
  endfunction

  function automatic logic [WORD_W-1:0] entry_ctl0(logic [WORD_W-1:0] v);
    return v & 32'h7FFF_FFF2;
  endfunction

  function automatic logic [SEL_W-1:0] entry_cs_sel(logic [WORD_W-1:0] base);
    return base[19:4];
  endfunction
endpackage

// File: rtl/sysmgmt_image.sv
`timescale 1ns/1ps
module sysmgmt_image
  import sysmgmt_pkg::*;
(
  input  snap_t              img,
  input  logic [SLOT_W-1:0]  slot,
  output logic [WORD_W-1:0]  word
);
  always_comb begin
    word = '0;
    case (int'(slot))
      SLOT_CTL0:  word = img.ctl0;
      SLOT_CTL3:  word = img.ctl3;
      SLOT_FLAGS: word = img.flags;
      SLOT_IP:    word = img.ip;
      SLOT_DBG6:  word = img.dbg6;
      SLOT_DBG7:  word = img.dbg7;
      SLOT_TR:    word = {{(WORD_W-SEL_W){1'b0}}, img.tr_sel};
      SLOT_BASE:  word = img.base;
      default:    ;
    endcase
    for (int g = 0; g < NUM_GPR; g++)
      if (int'(slot) == SLOT_GPR0 - g) word = img.gpr[g];
    for (int s = 0; s < NUM_SEG; s++)
      if (int'(slot) == SLOT_SEG0 - s) word = {{(WORD_W-SEL_W){1'b0}}, img.seg_sel[s]};
  end
endmodule

// File: rtl/sysmgmt_unpack.sv
`timescale 1ns/1ps
module sysmgmt_unpack
  import sysmgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [WORD_W-1:0]  rdata,
  output restore_t           img
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img <= '0;
    end else if (cap_en) begin
      case (int'(slot))
        SLOT_CTL0:  img.ctl0  <= rdata;
        SLOT_CTL3:  img.ctl3  <= rdata;
        SLOT_FLAGS: img.flags <= rdata;
        SLOT_IP:    img.ip    <= rdata;
        SLOT_DBG6:  img.dbg6  <= rdata;
        SLOT_DBG7:  img.dbg7  <= rdata;
        SLOT_BASE:  img.base  <= rdata;
        default:    ;
      endcase
      for (int g = 0; g < NUM_GPR; g++)
        if (int'(slot) == SLOT_GPR0 - g) img.gpr[g] <= rdata;
    end
  end
endmodule

// File: rtl/sysmgmt_ctrl.sv
`timescale 1ns/1ps
module sysmgmt_ctrl
  import sysmgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mgmt_irq,
  input  logic               resume_req,
  input  logic               mem_ack,
  output phase_t             phase,
  output logic [SLOT_W-1:0]  slot,
  output logic               take_irq,
  output logic               take_resume,
  output logic               in_mgmt,
  output logic               nmi_blk,
  output logic               ud_fault
);
  logic last_slot;
  assign last_slot   = (slot == SLOT_W'(IMG_WORDS-1));
  assign take_irq    = (phase == PH_IDLE) && mgmt_irq && !in_mgmt;
  assign take_resume = (phase == PH_IDLE) && resume_req && in_mgmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      slot     <= '0;
      in_mgmt  <= 1'b0;
      nmi_blk  <= 1'b0;
      ud_fault <= 1'b0;
    end else begin
      ud_fault <= (phase == PH_IDLE) && resume_req && !in_mgmt;
      case (phase)
        PH_IDLE: begin
          if (take_irq) begin
            phase <= PH_SAVE; slot <= '0;
          end else if (take_resume) begin
            phase <= PH_LOAD; slot <= '0;
          end
        end
        PH_SAVE, PH_LOAD: begin
          if (mem_ack) begin
            if (last_slot) phase <= (phase == PH_SAVE) ? PH_ENTER : PH_EXIT;
            else           slot  <= slot + 1'b1;
          end
        end
        PH_ENTER: begin
          phase <= PH_IDLE; in_mgmt <= 1'b1; nmi_blk <= 1'b1;
        end
        default: begin
          phase <= PH_IDLE; in_mgmt <= 1'b0; nmi_blk <= 1'b0;
        end
      endcase
    end
  end

  // R6
  smi_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && in_mgmt && mgmt_irq && !resume_req) |=> (phase == PH_IDLE && in_mgmt));
endmodule

// File: rtl/sysmgmt_seq.sv
`timescale 1ns/1ps
module sysmgmt_seq
  import sysmgmt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mgmt_irq,
  input  logic                        resume_req,
  input  logic [WORD_W-1:0]           snap_ctl0,
  input  logic [WORD_W-1:0]           snap_ctl3,
  input  logic [WORD_W-1:0]           snap_flags,
  input  logic [WORD_W-1:0]           snap_ip,
  input  logic [NUM_GPR*WORD_W-1:0]   snap_gpr,
  input  logic [WORD_W-1:0]           snap_dbg6,
  input  logic [WORD_W-1:0]           snap_dbg7,
  input  logic [SEL_W-1:0]            snap_tr_sel,
  input  logic [NUM_SEG*SEL_W-1:0]    snap_seg_sel,
  input  logic [WORD_W-1:0]           snap_save_base,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [WORD_W-1:0]           mem_addr,
  output logic [WORD_W-1:0]           mem_wdata,
  input  logic                        mem_ack,
  input  logic [WORD_W-1:0]           mem_rdata,
  output logic                        ld_stb,
  output logic                        ld_entry,
  output logic [WORD_W-1:0]           ld_ctl0,
  output logic [WORD_W-1:0]           ld_ctl3,
  output logic [WORD_W-1:0]           ld_ctl4,
  output logic [WORD_W-1:0]           ld_flags,
  output logic [WORD_W-1:0]           ld_ip,
  output logic [NUM_GPR*WORD_W-1:0]   ld_gpr,
  output logic [WORD_W-1:0]           ld_dbg6,
  output logic [WORD_W-1:0]           ld_dbg7,
  output logic [WORD_W-1:0]           ld_save_base,
  output logic [SEL_W-1:0]            ld_cs_sel,
  output logic [WORD_W-1:0]           ld_cs_base,
  output logic [WORD_W-1:0]           ld_data_base,
  output logic [SEL_W-1:0]            ld_seg_limit,
  output logic                        busy,
  output logic                        in_mgmt,
  output logic                        nmi_blk,
  output logic                        ud_fault
);
  localparam logic [WORD_W-1:0] ENTRY_FLAGS = 32'h0000_0002;
  localparam logic [WORD_W-1:0] ENTRY_IP    = 32'h0000_8000;
  localparam logic [WORD_W-1:0] ENTRY_DBG7  = 32'h0000_0400;

  phase_t             phase;
  logic [SLOT_W-1:0]  slot;
  logic               take_irq, take_resume;
  snap_t              snap_in, snap_q;
  restore_t           rest;
  logic [WORD_W-1:0]  base_q, img_word;
  logic               cap_en;

  assign snap_in = '{ctl0: snap_ctl0, ctl3: snap_ctl3, flags: snap_flags, ip: snap_ip,
                     gpr: snap_gpr, dbg6: snap_dbg6, dbg7: snap_dbg7, tr_sel: snap_tr_sel,
                     seg_sel: snap_seg_sel, base: snap_save_base};

  sysmgmt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mgmt_irq(mgmt_irq), .resume_req(resume_req),
    .mem_ack(mem_ack), .phase(phase), .slot(slot), .take_irq(take_irq),
    .take_resume(take_resume), .in_mgmt(in_mgmt), .nmi_blk(nmi_blk), .ud_fault(ud_fault)
  );

  sysmgmt_image u_image (.img(snap_q), .slot(slot), .word(img_word));

  assign cap_en = (phase == PH_LOAD) && mem_ack;
  sysmgmt_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .slot(slot), .rdata(mem_rdata), .img(rest)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      base_q <= '0;
    end else begin
      if (take_irq) snap_q <= snap_in;
      if (take_irq || take_resume) base_q <= snap_save_base;
    end
  end

  assign mem_req   = (phase == PH_SAVE) || (phase == PH_LOAD);
  assign mem_we    = (phase == PH_SAVE);
  assign mem_addr  = mem_req ? word_addr(base_q, slot) : '0;
  assign mem_wdata = mem_we ? img_word : '0;

  assign busy     = (phase != PH_IDLE);
  assign ld_stb   = (phase == PH_ENTER) || (phase == PH_EXIT);
  assign ld_entry = (phase == PH_ENTER);

  always_comb begin
    if (ld_entry) begin
      ld_ctl0      = entry_ctl0(snap_q.ctl0);
      ld_ctl3      = snap_q.ctl3;
      ld_flags     = ENTRY_FLAGS;
      ld_ip        = ENTRY_IP;
      ld_gpr       = snap_q.gpr;
      ld_dbg6      = snap_q.dbg6;
      ld_dbg7      = ENTRY_DBG7;
      ld_save_base = snap_q.base;
    end else begin
      ld_ctl0      = rest.ctl0;
      ld_ctl3      = rest.ctl3;
      ld_flags     = rest.flags;
      ld_ip        = rest.ip;
      ld_gpr       = rest.gpr;
      ld_dbg6      = rest.dbg6;
      ld_dbg7      = rest.dbg7;
      ld_save_base = rest.base;
    end
  end

  assign ld_ctl4      = '0;
  assign ld_cs_sel    = entry_cs_sel(ld_save_base);
  assign ld_cs_base   = ld_save_base;
  assign ld_data_base = '0;
  assign ld_seg_limit = {SEL_W{1'b1}};

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) - 32'd4));
  // R5
  enter_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mgmt) |-> ($past(ld_stb && ld_entry) && nmi_blk));
  // R7
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && !mgmt_irq && !in_mgmt && !busy) |=> (ud_fault && !mem_req && !busy));
  // R8
  read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && in_mgmt) |-> !mem_we);
  // R9
  exit_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_mgmt) |-> ($past(ld_stb && !ld_entry) && !nmi_blk));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n) ld_stb |-> busy);
  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(ld_stb));
endmodule

// File: tb/sysmgmt_seq_bench.sv
`timescale 1ns/1ps
module sysmgmt_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic mgmt_irq = 0, resume_req = 0;
  logic [31:0] snap_ctl0 = 0, snap_ctl3 = 0, snap_flags = 0, snap_ip = 0;
  logic [255:0] snap_gpr = 0;
  logic [31:0] snap_dbg6 = 0, snap_dbg7 = 0;
  logic [15:0] snap_tr_sel = 0;
  logic [95:0] snap_seg_sel = 0;
  logic [31:0] snap_save_base = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic ld_stb, ld_entry, busy, in_mgmt, nmi_blk, ud_fault;
  logic [31:0] ld_ctl0, ld_ctl3, ld_ctl4, ld_flags, ld_ip, ld_dbg6, ld_dbg7, ld_save_base;
  logic [31:0] ld_cs_base, ld_data_base;
  logic [255:0] ld_gpr;
  logic [15:0] ld_cs_sel, ld_seg_limit;

  sysmgmt_seq u_sysmgmt_seq (.*);

  int checks = 0, errors = 0;
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected snapshot, taken by the bench in the accepting cycle
  logic [31:0] e_ctl0, e_ctl3, e_flags, e_ip, e_dbg6, e_dbg7, e_base;
  logic [31:0] e_gpr [8];
  logic [15:0] e_tr, e_seg [6];

  function automatic bit is_field(int off);
    return (off >= 'h7FA8 && off <= 'h7FFC && off != 'h7FC0) || off == 'h7EF8;
  endfunction

  function automatic logic [31:0] exp_word(int off);
    if (off == 'h7FFC) return e_ctl0;
    if (off == 'h7FF8) return e_ctl3;
    if (off == 'h7FF4) return e_flags;
    if (off == 'h7FF0) return e_ip;
    if (off >= 'h7FD0 && off <= 'h7FEC) return e_gpr[(off - 'h7FD0) / 4];
    if (off == 'h7FCC) return e_dbg6;
    if (off == 'h7FC8) return e_dbg7;
    if (off == 'h7FC4) return {16'h0, e_tr};
    if (off >= 'h7FA8 && off <= 'h7FBC) return {16'h0, e_seg[(off - 'h7FA8) / 4]};
    if (off == 'h7EF8) return e_base;
    return 32'h0;
  endfunction

  // memory model and transaction monitor
  logic [31:0] mem [logic [31:0]];
  logic [31:0] cur_base = 0;
  logic exp_we = 1'b1;
  int xfer_n = 0, addr_bad = 0, fld_bad = 0, rsv_bad = 0, we_bad = 0, stab_bad = 0;
  function automatic logic [31:0] a_of(int off);
    return cur_base + 32'h8000 + 32'(off);
  endfunction

  initial begin
    int wait_left = 0;
    bit pend = 0;
    logic [31:0] p_addr = 0, p_data = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (pend && (mem_addr !== p_addr || mem_wdata !== p_data)) stab_bad++;
        pend = 1; p_addr = mem_addr; p_data = mem_wdata;
        if (wait_left > 0) wait_left--;
        else begin
          int off;
          off = 'h7FFC - 4 * xfer_n;
          if (mem_addr !== a_of(off)) addr_bad++;
          if (mem_we !== exp_we) we_bad++;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            if (mem_wdata !== exp_word(off)) begin
              if (is_field(off)) fld_bad++; else rsv_bad++;
            end
          end else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          mem_ack = 1'b1; pend = 0; xfer_n++;
          wait_left = $urandom_range(0, 2);
        end
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic randomize_snap();
    snap_ctl0 = $urandom; snap_ctl3 = $urandom; snap_flags = $urandom; snap_ip = $urandom;
    for (int g = 0; g < 8; g++) snap_gpr[32*g +: 32] = $urandom;
    snap_dbg6 = $urandom; snap_dbg7 = $urandom; snap_tr_sel = 16'($urandom);
    for (int s = 0; s < 6; s++) snap_seg_sel[16*s +: 16] = 16'($urandom);
    snap_save_base = $urandom;
  endtask

  task automatic clear_mon(logic we);
    exp_we = we; xfer_n = 0; addr_bad = 0; fld_bad = 0; rsv_bad = 0; we_bad = 0; stab_bad = 0;
  endtask

  task automatic wait_ld();
    int n = 0;
    while (ld_stb !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic do_entry(logic [31:0] base, bit mid_irq);
    randomize_snap();
    snap_save_base = base;
    e_ctl0 = snap_ctl0; e_ctl3 = snap_ctl3; e_flags = snap_flags; e_ip = snap_ip;
    for (int g = 0; g < 8; g++) e_gpr[g] = snap_gpr[32*g +: 32];
    e_dbg6 = snap_dbg6; e_dbg7 = snap_dbg7; e_tr = snap_tr_sel; e_base = base;
    for (int s = 0; s < 6; s++) e_seg[s] = snap_seg_sel[16*s +: 16];
    cur_base = base; clear_mon(1'b1);
    mgmt_irq = 1; @(negedge clk); mgmt_irq = 0;
    randomize_snap();
    chk("R11 busy after accept", 32'(busy), 1);
    if (mid_irq) begin
      repeat (5) @(negedge clk);
      mgmt_irq = 1; @(negedge clk); mgmt_irq = 0;
    end
    wait_ld();
    chk("R5 ld_stb", 32'(ld_stb), 1);
    chk("R5 ld_entry", 32'(ld_entry), 1);
    chk("R11 busy at load", 32'(busy), 1);
    chk("R2 write count", 32'(xfer_n), 128);
    chk("R2 address order", 32'(addr_bad), 0);
    chk("R2 write enable", 32'(we_bad), 0);
    chk("R3 field words", 32'(fld_bad), 0);
    chk("R4 reserved words", 32'(rsv_bad), 0);
    chk("R10 hold", 32'(stab_bad), 0);
    chk("R5 ctl0", ld_ctl0, e_ctl0 & ~32'h8000_000D);
    chk("R5 ctl4", ld_ctl4, 0);
    chk("R5 dbg7", ld_dbg7, 32'h400);
    chk("R5 flags", ld_flags, 32'h2);
    chk("R5 ip", ld_ip, 32'h8000);
    chk("R5 cs_sel", 32'(ld_cs_sel), 32'(base >> 4) & 32'hFFFF);
    chk("R5 cs_base", ld_cs_base, base);
    chk("R5 data_base", ld_data_base, 0);
    chk("R5 limit", 32'(ld_seg_limit), 32'hFFFF);
    @(negedge clk);
    chk("R5 in_mgmt", 32'(in_mgmt), 1);
    chk("R5 nmi_blk", 32'(nmi_blk), 1);
    chk("R11 busy drop", 32'(busy), 0);
    chk("R6 no extra writes", 32'(xfer_n), 128);
  endtask

  task automatic irq_in_mode();
    mgmt_irq = 1; @(negedge clk); mgmt_irq = 0;
    chk("R6 busy", 32'(busy), 0);
    chk("R6 mem_req", 32'(mem_req), 0);
    @(negedge clk);
    chk("R6 in_mgmt", 32'(in_mgmt), 1);
    chk("R6 count", 32'(xfer_n), 128);
  endtask

  task automatic do_resume();
    // handler rewrites every restorable slot
    foreach (e_gpr[g]) mem[a_of('h7FD0 + 4*g)] = $urandom;
    mem[a_of('h7FFC)] = $urandom; mem[a_of('h7FF8)] = $urandom;
    mem[a_of('h7FF4)] = $urandom; mem[a_of('h7FF0)] = $urandom;
    mem[a_of('h7FCC)] = $urandom; mem[a_of('h7FC8)] = $urandom;
    mem[a_of('h7EF8)] = $urandom;
    snap_save_base = cur_base; clear_mon(1'b0);
    resume_req = 1; @(negedge clk); resume_req = 0;
    snap_save_base = $urandom;
    chk("R11 busy resume", 32'(busy), 1);
    wait_ld();
    chk("R9 ld_stb", 32'(ld_stb), 1);
    chk("R9 ld_entry", 32'(ld_entry), 0);
    chk("R8 read count", 32'(xfer_n), 128);
    chk("R8 address order", 32'(addr_bad), 0);
    chk("R8 read enable", 32'(we_bad), 0);
    chk("R10 hold", 32'(stab_bad), 0);
    chk("R9 ctl0", ld_ctl0, mem[a_of('h7FFC)]);
    chk("R9 ctl3", ld_ctl3, mem[a_of('h7FF8)]);
    chk("R9 flags", ld_flags, mem[a_of('h7FF4)]);
    chk("R9 ip", ld_ip, mem[a_of('h7FF0)]);
    for (int g = 0; g < 8; g++) chk("R9 gpr", ld_gpr[32*g +: 32], mem[a_of('h7FD0 + 4*g)]);
    chk("R9 dbg6", ld_dbg6, mem[a_of('h7FCC)]);
    chk("R9 dbg7", ld_dbg7, mem[a_of('h7FC8)]);
    chk("R9 save_base", ld_save_base, mem[a_of('h7EF8)]);
    @(negedge clk);
    chk("R9 in_mgmt", 32'(in_mgmt), 0);
    chk("R9 nmi_blk", 32'(nmi_blk), 0);
    chk("R11 busy drop", 32'(busy), 0);
  endtask

  task automatic do_fault();
    resume_req = 1; @(negedge clk); resume_req = 0;
    chk("R7 ud_fault", 32'(ud_fault), 1);
    chk("R7 mem_req", 32'(mem_req), 0);
    chk("R7 busy", 32'(busy), 0);
    @(negedge clk);
    chk("R7 ud_fault one cycle", 32'(ud_fault), 0);
    chk("R7 mem_req later", 32'(mem_req), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 in_mgmt", 32'(in_mgmt), 0);
    chk("R1 nmi_blk", 32'(nmi_blk), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 ld_stb", 32'(ld_stb), 0);
    chk("R1 ud_fault", 32'(ud_fault), 0);
    rst_n = 1;
    @(negedge clk);
    do_fault();
    do_entry(32'h0003_0000, 1'b1);
    irq_in_mode();
    do_resume();
    do_fault();
    do_entry(32'h0000_0000, 1'b0);
    do_resume();
    for (int k = 0; k < 3; k++) begin
      do_entry($urandom, k == 1);
      irq_in_mode();
      do_resume();
    end
    do_entry(32'hFFFF_0000, 1'b1);
    do_resume();
    do_fault();
    summary();
    $finish;
  end
endmodule